// File: doc/BRIEF.md
# Logic-View Register Slave

This block is an APB-attached peripheral that holds four 32-bit scratch registers and presents a set of read-only locations. Each read-only location returns a bitwise combination of those registers, computed at the moment of the read. The top eight words of a 4 KB window hold identification bytes. Software can write patterns into the scratch registers and read back NOT, AND, OR and XOR results. This makes the block a convenient bus-integration and data-path test target.

The block reacts to a transfer on the clock edge that ends the setup phase, which is when select is high and enable is low. A write lands in the chosen register on that edge. Read data is registered on the same edge and stays valid for the whole access phase. The block never stretches a transfer and never reports an error. Only address bits [11:2] take part in the decode, so the whole map repeats every 0x1000 bytes.

Top module: `lvr_slave`

## Requirements
- R1: On the first clock edge with `rst` high, the four scratch registers clear to 0 and `rdata` clears to 0. After reset, offset 0x10 reads 0xFFFFFFFF.
- R2: Only an edge with `sel`=1 and `enable`=0 starts a transfer. Edges with `sel`=0, or with `sel`=1 and `enable`=1, change no register and leave `rdata` at 0.
- R3: A write to offset 0x00, 0x04, 0x08 or 0x0C (word index 0 to 3) stores `wdata` in scratch register 0, 1, 2 or 3 respectively.
- R4: A read of word index 0 to 3 returns that scratch register. The value appears in `rdata` after the setup-phase edge and holds through the access phase.
- R5: The pairwise views are: 0x10 returns NOT reg0, 0x14 returns reg0 AND reg1, 0x18 returns reg1 OR reg2, and 0x1C returns reg2 XOR reg3.
- R6: The four-way views are: 0x20 returns the AND of reg0 to reg3, 0x24 returns their OR, and 0x28 returns their XOR.
- R7: Offsets 0x2C through 0xFDC read as 0. Writes to those offsets and to 0x10 through 0x28 leave all scratch registers unchanged.
- R8: The low byte of 0xFE0, 0xFE4, 0xFE8 and 0xFEC reads 0x06, 0x18, 0x04 and 0x00. This is the 32-bit value with part 0x806 in bits [11:0], designer 0x41 in bits [19:12], revision 0 in bits [23:20] and configuration 0 in bits [31:24]. The low byte of 0xFF0, 0xFF4, 0xFF8 and 0xFFC reads 0x0D, 0xF0, 0x05 and 0xB1. Bits [31:8] of all eight ID words read as 0.
- R9: Address bits [1:0] and bits above bit 11 are ignored, so every location aliases every 0x1000 bytes.
- R10: `rdata` is 0 whenever no read was started on the previous edge. `ready` is always 1 and `slverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Peripheral select |
| enable | input | 1 | Access-phase marker |
| write | input | 1 | 1 = write, 0 = read |
| addr | input | 32 | Byte address; only bits [11:2] are decoded |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ready | output | 1 | Constant 1; no wait states |
| slverr | output | 1 | Constant 0; no error responses |

## Verification
The assertions assume well-formed APB traffic. Each transfer has exactly one setup edge, followed by one access edge that holds the same control values, and the bus stays idle between transfers. The stimulus drives only such transfers, and separately some deliberately stray edges with `enable` already high or `sel` low. The assertions also assume `addr` and `wdata` are stable at the setup edge. Every control change is made on the falling clock edge. The sweeps cover all 1024 word indices for reads and all non-scratch indices for writes, with upper and lower address bits varied to exercise aliasing.

// File: rtl/lvr_pkg.sv
package lvr_pkg;
  localparam int NREG     = 4;
  localparam int NVIEW    = 7;
  localparam int IDX_W    = 10;
  localparam int REG_SW   = $clog2(NREG);
  localparam int VIEW_SW  = $clog2(NVIEW);
  localparam int VIEW_LO  = NREG;
  localparam int VIEW_HI  = NREG + NVIEW - 1;
  localparam int ID_WORDS = 8;
  localparam int ID_SW    = $clog2(ID_WORDS);

  typedef enum logic [VIEW_SW-1:0] {
    V_NOT0  = 3'd0,
    V_AND01 = 3'd1,
    V_OR12  = 3'd2,
    V_XOR23 = 3'd3,
    V_ANDA  = 3'd4,
    V_ORA   = 3'd5,
    V_XORA  = 3'd6
  } view_e;

  typedef struct packed {
    logic              is_reg;
    logic [REG_SW-1:0] reg_sel;
    logic              is_view;
    logic [VIEW_SW-1:0] view_sel;
    logic              is_id;
    logic [ID_SW-1:0]  id_sel;
  } dec_t;
endpackage

// File: rtl/lvr_decode.sv
module lvr_decode
  import lvr_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output dec_t             dec
);
  localparam logic [IDX_W-1:0] V_LO = IDX_W'(VIEW_LO);
  localparam logic [IDX_W-1:0] V_HI = IDX_W'(VIEW_HI);
  localparam logic [IDX_W-1:0] R_N  = IDX_W'(NREG);

  logic [IDX_W-1:0] vofs;

  always_comb begin
    vofs         = idx - V_LO;
    dec          = '0;
    dec.is_reg   = (idx < R_N);
    dec.reg_sel  = idx[REG_SW-1:0];
    dec.is_view  = (idx >= V_LO) && (idx <= V_HI);
    dec.view_sel = vofs[VIEW_SW-1:0];
    dec.is_id    = &idx[IDX_W-1:ID_SW];
    dec.id_sel   = idx[ID_SW-1:0];
  end
endmodule

// File: rtl/lvr_regbank.sv
module lvr_regbank
  import lvr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [REG_SW-1:0]            wsel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NREG-1:0][DATA_W-1:0]  regs
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (we && (wsel == REG_SW'(g))) begin
        regs[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/lvr_views.sv
module lvr_views
  import lvr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [NREG-1:0][DATA_W-1:0]  regs,
  output logic [NVIEW-1:0][DATA_W-1:0] views
);
  logic [NREG-1:0][DATA_W-1:0] and_c, or_c, xor_c;

  assign and_c[0] = regs[0];
  assign or_c[0]  = regs[0];
  assign xor_c[0] = regs[0];
  for (genvar g = 1; g < NREG; g++) begin : g_fold
    assign and_c[g] = and_c[g-1] & regs[g];
    assign or_c[g]  = or_c[g-1]  | regs[g];
    assign xor_c[g] = xor_c[g-1] ^ regs[g];
  end

  always_comb begin
    views          = '0;
    views[V_NOT0]  = ~regs[0];
    views[V_AND01] = regs[0] & regs[1];
    views[V_OR12]  = regs[1] | regs[2];
    views[V_XOR23] = regs[2] ^ regs[3];
    views[V_ANDA]  = and_c[NREG-1];
    views[V_ORA]   = or_c[NREG-1];
    views[V_XORA]  = xor_c[NREG-1];
  end
endmodule

// File: rtl/lvr_idrom.sv
module lvr_idrom
  import lvr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter logic [11:0] PART     = 12'h806,
  parameter logic [7:0]  DESIGNER = 8'h41,
  parameter logic [3:0]  REVISION = 4'h0,
  parameter logic [7:0]  CONFIG   = 8'h00,
  parameter logic [31:0] COMP_ID  = 32'hB105_F00D
) (
  input  logic [ID_SW-1:0]  sel,
  output logic [DATA_W-1:0] word
);
  localparam logic [31:0] PERIPH_ID = {CONFIG, REVISION, DESIGNER, PART};

  logic [31:0] src;
  logic [7:0]  byte_v;

  always_comb begin
    src    = sel[ID_SW-1] ? COMP_ID : PERIPH_ID;
    byte_v = src[8*sel[1:0] +: 8];
    word   = DATA_W'(byte_v);
  end
endmodule

// File: rtl/lvr_slave.sv
module lvr_slave
  import lvr_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 32,
  parameter logic [11:0] PART     = 12'h806,
  parameter logic [7:0]  DESIGNER = 8'h41,
  parameter logic [3:0]  REVISION = 4'h0,
  parameter logic [7:0]  CONFIG   = 8'h00,
  parameter logic [31:0] COMP_ID  = 32'hB105_F00D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              enable,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              slverr
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic                         setup_q;
  logic                         wr_acc, rd_acc;
  logic [IDX_W-1:0]             idx;
  dec_t                         dec;
  logic [NREG-1:0][DATA_W-1:0]  regs_q;
  logic [NVIEW-1:0][DATA_W-1:0] views;
  logic [DATA_W-1:0]            id_word;
  logic [DATA_W-1:0]            rd_mux;
  logic                         unused_addr;

  assign setup_q     = sel && !enable;
  assign wr_acc      = setup_q && write;
  assign rd_acc      = setup_q && !write;
  assign idx         = addr[IDX_HI:IDX_LO];
  assign unused_addr = ^{addr[ADDR_W-1:IDX_HI+1], addr[IDX_LO-1:0]};

  lvr_decode u_dec (
    .idx (idx),
    .dec (dec)
  );

  lvr_regbank #(.DATA_W(DATA_W)) u_bank (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_acc && dec.is_reg),
    .wsel  (dec.reg_sel),
    .wdata (wdata),
    .regs  (regs_q)
  );

  lvr_views #(.DATA_W(DATA_W)) u_views (
    .regs  (regs_q),
    .views (views)
  );

  lvr_idrom #(
    .DATA_W(DATA_W), .PART(PART), .DESIGNER(DESIGNER),
    .REVISION(REVISION), .CONFIG(CONFIG), .COMP_ID(COMP_ID)
  ) u_id (
    .sel  (dec.id_sel),
    .word (id_word)
  );

  always_comb begin
    rd_mux = '0;
    if (dec.is_reg) begin
      rd_mux = regs_q[dec.reg_sel];
    end else if (dec.is_view) begin
      rd_mux = views[dec.view_sel];
    end else if (dec.is_id) begin
      rd_mux = id_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_acc) begin
      rdata <= rd_mux;
    end else begin
      rdata <= '0;
    end
  end

  assign ready  = 1'b1;
  assign slverr = 1'b0;
endmodule

// File: rtl/lvr_slave_chk.sv
module lvr_slave_chk
  import lvr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        sel,
  input logic                        enable,
  input logic                        write,
  input logic [ADDR_W-1:0]           addr,
  input logic [DATA_W-1:0]           wdata,
  input logic [DATA_W-1:0]           rdata,
  input logic [NREG-1:0][DATA_W-1:0] regs_q
);
  logic [IDX_W-1:0] c_idx;
  logic             c_setup;
  logic             unused_chk;

  assign c_idx      = addr[11:2];
  assign c_setup    = sel && !enable;
  assign unused_chk = ^{addr[ADDR_W-1:12], addr[1:0]};

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(c_setup && !write) |=> (rdata == '0)); // R10

  AST_NO_SETUP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(c_setup && write) |=> $stable(regs_q)); // R2

  AST_REG_WRITE: assert property (@(posedge clk) disable iff (rst)
    (c_setup && write && (c_idx < IDX_W'(NREG)))
      |=> (regs_q[$past(c_idx[REG_SW-1:0])] == $past(wdata))); // R3

  AST_RO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (c_setup && write && (c_idx >= IDX_W'(NREG))) |=> $stable(regs_q)); // R7

  AST_REG_READ: assert property (@(posedge clk) disable iff (rst)
    (c_setup && !write && (c_idx < IDX_W'(NREG)))
      |=> (rdata == $past(regs_q[c_idx[REG_SW-1:0]]))); // R4

  AST_AND_VIEW: assert property (@(posedge clk) disable iff (rst)
    (c_setup && !write && (c_idx == 10'd5))
      |=> (rdata == ($past(regs_q[0]) & $past(regs_q[1])))); // R5

  AST_XOR_ALL: assert property (@(posedge clk) disable iff (rst)
    (c_setup && !write && (c_idx == 10'd10))
      |=> (rdata == ($past(regs_q[0]) ^ $past(regs_q[1]) ^
                     $past(regs_q[2]) ^ $past(regs_q[3])))); // R6

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (c_setup && !write && (c_idx >= 10'd11) && (c_idx < 10'd1016))
      |=> (rdata == '0)); // R7

  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (c_setup && !write && (c_idx >= 10'd1016))
      |=> (rdata[DATA_W-1:8] == '0)); // R8
endmodule

bind lvr_slave lvr_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .sel    (sel),
  .enable (enable),
  .write  (write),
  .addr   (addr),
  .wdata  (wdata),
  .rdata  (rdata),
  .regs_q (regs_q)
);

// File: tb/lvr_slave_tb_top.sv
`timescale 1ns/1ps
module lvr_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, enable = 1'b0, write = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        ready, slverr;

  int n_tot = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] m [4];

  always #10 clk = ~clk;

  lvr_slave dut_i (
    .clk(clk), .rst(rst), .sel(sel), .enable(enable), .write(write),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready), .slverr(slverr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] id_byte(input int k);
    logic [31:0] pid, cid;
    pid = (32'h0 << 24) | (32'h0 << 20) | (32'h41 << 12) | 32'h806;
    cid = 32'hB105F00D;
    return (k < 4) ? ((pid >> (8 * k)) & 32'hFF) : ((cid >> (8 * (k - 4))) & 32'hFF);
  endfunction

  function automatic logic [31:0] exp_read(input int i);
    case (i)
      0, 1, 2, 3: return m[i];
      4:  return ~m[0];
      5:  return m[0] & m[1];
      6:  return m[1] | m[2];
      7:  return m[2] ^ m[3];
      8:  return m[0] & m[1] & m[2] & m[3];
      9:  return m[0] | m[1] | m[2] | m[3];
      10: return m[0] ^ m[1] ^ m[2] ^ m[3];
      default: return (i >= 1016) ? id_byte(i - 1016) : 32'h0;
    endcase
  endfunction

  // One complete transfer; returns rdata seen during the access phase.
  task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    sel = 1'b1; enable = 1'b0; write = wr; addr = a; wdata = d;
    @(negedge clk);
    enable = 1'b1;
    rd = rdata;
    chk("R10 ready high", {31'b0, ready}, 32'h1);
    chk("R10 slverr low", {31'b0, slverr}, 32'h0);
    @(negedge clk);
    sel = 1'b0; enable = 1'b0; write = 1'b0;
    chk("R10 rdata idle after access", rdata, 32'h0);
  endtask

  task automatic wr_reg(input logic [31:0] a, input logic [31:0] d);
    logic [31:0] rd;
    xfer(1'b1, a, d, rd);
    chk("R10 rdata zero in write", rd, 32'h0);
  endtask

  task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
    logic [31:0] rd;
    xfer(1'b0, a, 32'h0, rd);
    chk(tag, rd, exp);
  endtask

  task automatic check_all_low(input string tag);
    for (int i = 0; i < 11; i++) rd_chk(tag, 32'(i * 4), exp_read(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pat;
    logic [31:0] rd;
    for (int i = 0; i < 4; i++) m[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset values
    check_all_low("R1 reset view");
    rd_chk("R1 not-r0 after reset", 32'h10, 32'hFFFFFFFF);

    // R3 R4 R5 R6: several pattern sets
    for (int s = 0; s < 6; s++) begin
      for (int r = 0; r < 4; r++) begin
        pat = 32'h9E3779B9 * (s * 4 + r + 1) ^ (32'h0F0F00FF << r);
        if (s == 4) pat = 32'hFFFFFFFF;
        if (s == 5) pat = (r == 2) ? 32'h0 : 32'hFFFFFFFF;
        wr_reg(32'(r * 4), pat);
        m[r] = pat;
      end
      for (int r = 0; r < 4; r++) rd_chk("R3 R4 reg readback", 32'(r * 4), m[r]);
      for (int i = 4; i < 8; i++) rd_chk("R5 pairwise view", 32'(i * 4), exp_read(i));
      for (int i = 8; i < 11; i++) rd_chk("R6 four-way view", 32'(i * 4), exp_read(i));
    end

    // R7 R8: full read sweep of the window
    for (int i = 0; i < 1024; i++) begin
      if (i >= 1016) rd_chk("R8 id byte", 32'(i * 4), exp_read(i));
      else if (i >= 11) rd_chk("R7 reserved reads zero", 32'(i * 4), 32'h0);
      else rd_chk("R4 R5 R6 sweep", 32'(i * 4), exp_read(i));
    end

    // R7: writes to every non-scratch location are ignored
    for (int i = 4; i < 1024; i++) wr_reg(32'(i * 4), 32'hA5A5_0000 | 32'(i));
    check_all_low("R7 regs unchanged after ro writes");
    rd_chk("R7 reserved still zero", 32'h100, 32'h0);
    rd_chk("R8 id unchanged", 32'hFE0, 32'h06);

    // R9: aliasing via upper and low address bits
    wr_reg(32'h0000_5007, 32'h1234_5678); m[1] = 32'h1234_5678;
    rd_chk("R9 alias read", 32'h0000_0004, 32'h1234_5678);
    rd_chk("R9 alias read high", 32'hFFFF_F006, 32'h1234_5678);
    wr_reg(32'h8000_300D, 32'hCAFE_F00D); m[3] = 32'hCAFE_F00D;
    rd_chk("R9 alias write", 32'h0000_000C, 32'hCAFE_F00D);
    rd_chk("R9 alias view", 32'h7000_1029, exp_read(10));
    rd_chk("R9 alias id", 32'h1234_5FFF, 32'hB1);
    rd_chk("R9 alias reserved", 32'h0000_1FDC, 32'h0);

    // R2: stray edges without a setup phase
    sel = 1'b1; enable = 1'b1; write = 1'b1; addr = 32'h0; wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R2 no read result on access-only edge", rdata, 32'h0);
    sel = 1'b0; enable = 1'b0; write = 1'b1; addr = 32'h4; wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    sel = 1'b1; enable = 1'b1; write = 1'b0; addr = 32'h10;
    @(negedge clk);
    chk("R2 access-only read gives zero", rdata, 32'h0);
    sel = 1'b0; enable = 1'b0; write = 1'b0;
    @(negedge clk);
    check_all_low("R2 regs unchanged by stray edges");

    // R1: reset in the middle of operation
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) m[i] = 32'h0;
    check_all_low("R1 re-reset");
    xfer(1'b0, 32'h28, 32'h0, rd);
    chk("R1 xor-all zero after reset", rd, 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule